// File: doc/BRIEF.md
# Registered Magnitude Comparator with Operand-Driven Lower-Bit Load Suppression

This block compares two unsigned operands and reports whether the first is strictly greater than the second, one clock after the operands are presented. The top bit of each operand is captured on every clock. The remaining bits go into a second register bank that takes new values only when the two incoming top bits match. When the top bits differ, they settle the comparison by themselves and the lower bank keeps its old contents, which removes its switching activity for that cycle.

With random operands the top bits differ about half the time, so the lower bank stays still on roughly half of all samples. The suppression is a synchronous clock enable on ordinary flops. No clock is derived from logic. Operands are sampled when an input valid strobe is high, and a matching output valid strobe marks each result.

Top module: `gated_gt_cmp`

## Requirements
- R1: When `inValid` is high at a rising edge with operands `opA` and `opB`, then after that edge `gtOut` equals (`opA` > `opB`) as unsigned numbers and `outValid` is 1.
- R2: The top-bit registers (bit WIDTH-1 of each operand) are loaded at every rising edge that is not in reset.
- R3: The lower bank (bits WIDTH-2..0 of both operands) loads only at an edge where `inValid` is 1 and bit WIDTH-1 of `opA` equals bit WIDTH-1 of `opB`. At every other edge it holds its value.
- R4: When the sampled top bits differ, `gtOut` equals the sampled top bit of `opA`, whatever the lower bits are.
- R5: When the sampled top bits are equal, `gtOut` is the unsigned comparison of the lower WIDTH-1 bits of the two operands.
- R6: When `inValid` is 0 at an edge, `outValid` is 0 after that edge, and the next valid sample still gives the correct result.
- R7: A synchronous active-high `rst` clears every register. After a reset edge `outValid` is 0 and `gtOut` is 0.
- R8: Equal operands, including all zeros and all ones, give `gtOut` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands on `opA`/`opB` are to be sampled |
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| gtOut | output | 1 | 1 when the last sampled `opA` exceeds `opB` |
| outValid | output | 1 | `gtOut` belongs to a valid sample |

## Verification
The assertions check the following on every cycle:
- the lower bank stays unchanged at any edge where its load enable is low;
- a top-bit mismatch alone decides the result;
- the result matches a full-width comparison of the operands sampled one cycle earlier;
- the valid strobe follows the input strobe;
- reset clears the output.

Only the bench scenarios can show that correct results survive specific orderings. These are a sample with matching top bits that follows a run of mismatched ones (it must use freshly loaded lower bits), idle cycles carrying lower-bit changes, and a reset in the middle of traffic. The bench also tallies how often its stimulus should have enabled the lower bank.

// File: rtl/gated_cmp_pkg.sv
package gated_cmp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;    // clock enable for the lower operand bank
    logic pushValid;  // a valid sample is being captured
  } cmpStrobes_t;
endpackage

// File: rtl/gated_cmp_ctrl.sv
module gated_cmp_ctrl
  import gated_cmp_pkg::*;
(
  input  logic        inValid,
  input  logic        topA,
  input  logic        topB,
  output cmpStrobes_t strobes
);
  always_comb begin
    strobes.pushValid = inValid;
    // lower bits matter only when the top bits agree
    strobes.loadLow   = inValid & ~(topA ^ topB);
  end
endmodule

// File: rtl/gated_cmp_datapath.sv
module gated_cmp_datapath
  import gated_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cmpStrobes_t      strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             gtOut,
  output logic             outValid
);
  localparam int TOP   = WIDTH - 1;
  localparam int LOW_W = WIDTH - 1;

  logic             topAReg, topBReg;
  logic [LOW_W-1:0] lowAReg, lowBReg;
  logic             validReg;
  logic             lowGt;

  // top bits: captured every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      topAReg <= 1'b0;
      topBReg <= 1'b0;
    end else begin
      topAReg <= opA[TOP];
      topBReg <= opB[TOP];
    end
  end

  // lower bank: clock-enabled by strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      lowAReg <= '0;
      lowBReg <= '0;
    end else if (strobes.loadLow) begin
      lowAReg <= opA[LOW_W-1:0];
      lowBReg <= opB[LOW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) validReg <= 1'b0;
    else     validReg <= strobes.pushValid;
  end

  assign lowGt = (lowAReg > lowBReg);

  always_comb begin
    if (topAReg != topBReg) gtOut = topAReg & ~topBReg;
    else                    gtOut = lowGt;
  end

  assign outValid = validReg;

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadLow |=> ($stable(lowAReg) && $stable(lowBReg))); // R3

  AST_TOP_DECIDES: assert property (@(posedge clk) disable iff (rst)
    (outValid && ($past(opA[TOP]) != $past(opB[TOP]))) |-> (gtOut == $past(opA[TOP]))); // R4

  AST_FULL_RESULT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (gtOut == ($past(opA) > $past(opB)))); // R1

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    strobes.pushValid |=> outValid); // R1

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !strobes.pushValid |=> !outValid); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!outValid && !gtOut)); // R7
endmodule

// File: rtl/gated_gt_cmp.sv
module gated_gt_cmp
  import gated_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             gtOut,
  output logic             outValid
);
  cmpStrobes_t strobes;

  gated_cmp_ctrl i_ctrl (
    .inValid (inValid),
    .topA    (opA[WIDTH-1]),
    .topB    (opB[WIDTH-1]),
    .strobes (strobes)
  );

  gated_cmp_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .gtOut    (gtOut),
    .outValid (outValid)
  );
endmodule

// File: tb/test_gated_gt_cmp.sv
module test_gated_gt_cmp;
  localparam int WIDTH = 8;
  localparam int CLK_PERIOD = 10;
  localparam int TOP = WIDTH - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic             gtOut, outValid;

  int checks = 0;
  int fails  = 0;
  int enCount = 0;
  int sampleCount = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  logic  qValid[$];
  logic  qGt[$];
  string qTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_gt_cmp #(.WIDTH(WIDTH)) i_gated_gt_cmp (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .gtOut(gtOut), .outValid(outValid)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one sample per cycle, expected item into the scoreboard
  task automatic drive(input logic v, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input string tag);
    @(negedge clk);
    #1;
    inValid = v; opA = a; opB = b;
    qValid.push_back(v);
    qGt.push_back(a > b);
    qTag.push_back(tag);
    if (v) begin
      sampleCount++;
      if (a[TOP] == b[TOP]) enCount++;
    end
  endtask

  // monitor: compare at falling edges, after the design's register update
  always @(negedge clk) begin
    if (monOn && qValid.size() > 0) begin
      logic  ev, eg;
      string t;
      ev = qValid.pop_front();
      eg = qGt.pop_front();
      t  = qTag.pop_front();
      check({t, " valid"}, outValid, ev);
      if (ev) check({t, " gt"}, gtOut, eg);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst = 1'b1; monOn = 1'b0; inValid = 1'b0;
    qValid.delete(); qGt.delete(); qTag.delete();
    @(negedge clk);
    check("R7 reset valid", outValid, 1'b0);
    check("R7 reset gt", gtOut, 1'b0);
    #1;
    rst = 1'b0; monOn = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset();

    // R8 equal operands
    drive(1, 8'h00, 8'h00, "R8 zeros");
    drive(1, 8'hFF, 8'hFF, "R8 ones");
    drive(1, 8'h5A, 8'h5A, "R8 equal");
    // R4 top bits decide
    drive(1, 8'h80, 8'h7F, "R4 a top");
    drive(1, 8'h00, 8'hFF, "R4 b top");
    drive(1, 8'hFF, 8'h00, "R4 max");
    // R5 lower bits decide
    drive(1, 8'h7F, 8'h7E, "R5 low gt");
    drive(1, 8'h80, 8'h81, "R5 low lt");
    drive(1, 8'hC3, 8'hC3, "R5 low eq");
    // R3 equal-top sample after run of mismatched ones uses fresh low bits
    drive(1, 8'h85, 8'h83, "R3 load");
    drive(1, 8'h01, 8'h80, "R3 skip1");
    drive(1, 8'hFE, 8'h7F, "R3 skip2");
    drive(1, 8'h02, 8'h05, "R3 fresh");
    // R6 idle cycles with changing operands
    drive(0, 8'h7F, 8'h00, "R6 idle");
    drive(0, 8'h00, 8'h7F, "R6 idle");
    drive(1, 8'h10, 8'h11, "R6 after idle");
    // R2 top bits reloaded each cycle
    drive(1, 8'h80, 8'h00, "R2 top1");
    drive(1, 8'h00, 8'h80, "R2 top2");
    drive(1, 8'h80, 8'h00, "R2 top3");

    // R1 random traffic
    for (int i = 0; i < 400; i++) begin
      logic [WIDTH-1:0] a, b;
      logic v;
      a = WIDTH'($urandom);
      b = WIDTH'($urandom);
      v = ($urandom % 8) != 0;
      drive(v, a, b, (a[TOP] != b[TOP]) ? "R1 R4 rand" : "R1 R5 rand");
    end

    // R7 reset during traffic
    drive(1, 8'hF0, 8'h0F, "R7 pre");
    do_reset();
    drive(1, 8'h3C, 8'h3B, "R7 post");
    drive(0, 8'h00, 8'h00, "R7 idle");
    repeat (3) @(negedge clk);

    $display("lower-bank enables expected: %0d of %0d valid samples", enCount, sampleCount);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule